// File: doc/BRIEF.md
# UART multidrop address filter

This block follows a nine-bit UART receiver on a shared multidrop line. Every received character carries a ninth marker bit. A marker of 1 means the character is an address byte, and 0 means a data byte. The block decides, byte by byte, whether the receiver should interrupt the processor. It also keeps two status flags that software reads alongside the byte: one says the byte was an address, and one says the byte is the first data byte of a frame addressed to this node.

There are four filtering policies, chosen by a two-bit mode and armed by a multiprocessor enable bit:

- **Mode 00:** interrupts on every byte.
- **Mode 01:** interrupts on address bytes only. Software inspects each address and clears the low mode bit to open the filter.
- **Mode 10:** compares each address byte with the node's own address in hardware. It interrupts on a matching address and on the data that follows it.
- **Mode 11:** like mode 10, but stays silent on address bytes.

A three-state frame machine tracks the hardware-compare modes:

| State | Meaning |
|---|---|
| `ST_HUNT` | No frame accepted |
| `ST_AWAIT_FIRST` | Matched, waiting for the first clean data byte |
| `ST_IN_FRAME` | Matched, first data byte already seen |

Its transitions are:

| Transition | Cause | Effect |
|---|---|---|
| *match* | An address byte equal to the own address, in a hardware mode | Any state to `ST_AWAIT_FIRST` |
| *miss* | An address byte that differs, in a hardware mode | Any state to `ST_HUNT` |
| *first* | A data byte without framing error, in a hardware mode | `ST_AWAIT_FIRST` to `ST_IN_FRAME` |
| *resync* | Any change of mode or enable | Any state to `ST_HUNT`; takes priority over a byte in the same cycle |

Top module: `mdrop_addr_filter`

## Requirements
- R1: After reset, the interrupt output and both status flags are 0. No frame is accepted, so in mode 10 a data byte received before any address byte does not interrupt.
- R2: While the enable bit is 0, every valid byte interrupts, including address bytes and bytes with a framing error.
- R3: The interrupt output is high only in a cycle where the byte-valid strobe is high. It is combinational from that strobe and lasts one cycle.
- R4: With enable 1 and mode 01, an address byte (marker 1) interrupts and a data byte (marker 0) does not.
- R5: With enable 1 and mode 00, every valid byte interrupts.
- R6: The address flag is updated at the clock edge that takes a valid byte. It holds that byte's marker bit until the next valid byte. The new-frame flag is updated at the same edge and is held in the same way.
- R7: In mode 10, an address byte equal to the own address interrupts, and every following data byte of that frame without a framing error also interrupts.
- R8: In modes 10 and 11, an address byte that differs from the own address does not interrupt. The data bytes after it do not interrupt until the next address byte.
- R9: In modes 10 and 11, the new-frame flag becomes 1 after the first data byte without a framing error that follows a matching address. It becomes 0 after any other byte. A later matching address arms the flag again.
- R10: In mode 11, address bytes never interrupt, while data bytes of a matched frame do.
- R11: In modes 10 and 11, a data byte with a framing error does not interrupt, leaves the new-frame flag at 0, and does not count as the first data byte of the frame.
- R12: A change of mode or enable drops any accepted frame. After the change, data bytes in a hardware mode are ignored until a matching address arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | One-cycle strobe: a received character is present |
| rx_data | input | 8 | Received byte |
| rx_is_addr | input | 1 | Ninth bit: 1 = address byte, 0 = data byte |
| rx_frame_err | input | 1 | The character had a bad stop bit |
| mode_sel | input | 2 | Filtering policy 00/01/10/11 |
| mp_enable | input | 1 | 1 = multidrop filtering active |
| own_addr | input | 8 | This node's address |
| rx_irq | output | 1 | Receive interrupt request, same cycle as rx_valid |
| new_frame | output | 1 | Held flag: last byte was the first data byte of a matched frame |
| addr_flag | output | 1 | Held flag: last byte was an address byte |

## Verification
The interrupt is combinational, so it is due in the same cycle as the strobe. The bench drives each byte just after a rising edge and reads the interrupt at the following falling edge. The two flags come from registers loaded at the edge that takes the byte, so they are read at the falling edge after it, once the strobe is low again. The same sample also confirms that the interrupt has returned to 0. A mode change is applied one full cycle before the next byte, so that the resync edge has passed; the hold tests then idle several cycles before reading the flags again.

// File: rtl/mdrop_pkg.sv
`timescale 1ns/1ps
package mdrop_pkg;

    // Filtering policy; bit 1 selects hardware address compare.
    typedef enum logic [1:0] {
        MD_ALL      = 2'b00,
        MD_ADDR_IRQ = 2'b01,
        MD_HW_MATCH = 2'b10,
        MD_HW_QUIET = 2'b11
    } mdrop_mode_e;

    // Frame acceptance state for the hardware-compare policies.
    typedef enum logic [1:0] {
        ST_HUNT        = 2'b00,
        ST_AWAIT_FIRST = 2'b01,
        ST_IN_FRAME    = 2'b10
    } frame_st_e;

endpackage

// File: rtl/mdrop_cfg_watch.sv
`timescale 1ns/1ps
module mdrop_cfg_watch #(
    parameter int CFG_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] cfg_in,
    output logic             cfg_chg
);

    logic [CFG_W-1:0] cfg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_in;
        end
    end

    assign cfg_chg = (cfg_q != cfg_in);

endmodule

// File: rtl/mdrop_addr_cmp.sv
`timescale 1ns/1ps
module mdrop_addr_cmp #(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] rx_byte,
    input  logic [ADDR_W-1:0] own_addr,
    output logic              hit
);

    logic [ADDR_W-1:0] bit_eq;

    for (genvar b = 0; b < ADDR_W; b++) begin : g_bit
        assign bit_eq[b] = ~(rx_byte[b] ^ own_addr[b]);
    end

    assign hit = &bit_eq;

endmodule

// File: rtl/mdrop_frame_fsm.sv
`timescale 1ns/1ps
module mdrop_frame_fsm
    import mdrop_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_chg,
    input  logic       rx_valid,
    input  logic       rx_is_addr,
    input  logic       rx_frame_err,
    input  logic       mp_enable,
    input  logic [1:0] mode_sel,
    input  logic       addr_hit,
    output logic       irq,
    output logic       first_data
);

    frame_st_e   state_q, state_d;
    mdrop_mode_e mode;
    logic        hw_mode;
    logic        accepted;
    logic        clean_data;

    assign mode       = mdrop_mode_e'(mode_sel);
    assign hw_mode    = mp_enable && mode_sel[1];
    assign accepted   = (state_q != ST_HUNT);
    assign clean_data = rx_valid && !rx_is_addr && !rx_frame_err;

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        if (cfg_chg) begin
            state_d = ST_HUNT;                                   // resync
        end else if (hw_mode && rx_valid && rx_is_addr) begin
            state_d = addr_hit ? ST_AWAIT_FIRST : ST_HUNT;       // match / miss
        end else if (hw_mode && clean_data) begin
            unique case (state_q)
                ST_AWAIT_FIRST: state_d = ST_IN_FRAME;           // first
                ST_HUNT:        state_d = ST_HUNT;
                ST_IN_FRAME:    state_d = ST_IN_FRAME;
                default:        state_d = ST_HUNT;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs.
    always_comb begin
        irq        = 1'b0;
        first_data = 1'b0;
        if (rx_valid) begin
            if (!mp_enable) begin
                irq = 1'b1;
            end else begin
                unique case (mode)
                    MD_ALL:      irq = 1'b1;
                    MD_ADDR_IRQ: irq = rx_is_addr;
                    MD_HW_MATCH: irq = rx_is_addr ? addr_hit
                                                  : (accepted && !rx_frame_err);
                    MD_HW_QUIET: irq = !rx_is_addr && accepted && !rx_frame_err;
                    default:     irq = 1'b0;
                endcase
                first_data = hw_mode && clean_data && (state_q == ST_AWAIT_FIRST);
            end
        end
    end

endmodule

// File: rtl/mdrop_status.sv
`timescale 1ns/1ps
module mdrop_status (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_valid,
    input  logic rx_is_addr,
    input  logic first_data,
    output logic new_frame,
    output logic addr_flag
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            new_frame <= 1'b0;
            addr_flag <= 1'b0;
        end else if (rx_valid) begin
            new_frame <= first_data;
            addr_flag <= rx_is_addr;
        end
    end

endmodule

// File: rtl/mdrop_addr_filter.sv
`timescale 1ns/1ps
module mdrop_addr_filter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_is_addr,
    input  logic              rx_frame_err,
    input  logic [1:0]        mode_sel,
    input  logic              mp_enable,
    input  logic [DATA_W-1:0] own_addr,
    output logic              rx_irq,
    output logic              new_frame,
    output logic              addr_flag
);

    localparam int CFG_W = 3;

    logic cfg_chg;
    logic addr_hit;
    logic first_data;

    mdrop_cfg_watch #(.CFG_W(CFG_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_in  ({mp_enable, mode_sel}),
        .cfg_chg (cfg_chg)
    );

    mdrop_addr_cmp #(.ADDR_W(DATA_W)) u_cmp (
        .rx_byte  (rx_data),
        .own_addr (own_addr),
        .hit      (addr_hit)
    );

    mdrop_frame_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_chg      (cfg_chg),
        .rx_valid     (rx_valid),
        .rx_is_addr   (rx_is_addr),
        .rx_frame_err (rx_frame_err),
        .mp_enable    (mp_enable),
        .mode_sel     (mode_sel),
        .addr_hit     (addr_hit),
        .irq          (rx_irq),
        .first_data   (first_data)
    );

    mdrop_status u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_valid   (rx_valid),
        .rx_is_addr (rx_is_addr),
        .first_data (first_data),
        .new_frame  (new_frame),
        .addr_flag  (addr_flag)
    );

endmodule

// File: rtl/mdrop_addr_filter_chk.sv
`timescale 1ns/1ps
module mdrop_addr_filter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_valid,
    input logic       rx_is_addr,
    input logic       rx_frame_err,
    input logic [1:0] mode_sel,
    input logic       mp_enable,
    input logic       rx_irq,
    input logic       new_frame,
    input logic       addr_flag
);

    // R3
    irq_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> rx_valid);

    // R2
    disabled_all_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !mp_enable) |-> rx_irq);

    // R5
    mode00_all_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && mp_enable && mode_sel == 2'b00) |-> rx_irq);

    // R4
    mode01_data_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && mp_enable && mode_sel == 2'b01 && !rx_is_addr) |-> !rx_irq);

    // R10
    mode11_addr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && mp_enable && mode_sel == 2'b11 && rx_is_addr) |-> !rx_irq);

    // R11
    ferr_data_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && mp_enable && mode_sel[1] && !rx_is_addr && rx_frame_err)
        |-> !rx_irq);

    // R6
    flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |=> ($stable(new_frame) && $stable(addr_flag)));

    // R6
    addr_flag_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> (addr_flag == $past(rx_is_addr)));

    // R9
    new_frame_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        new_frame |-> !addr_flag);

endmodule

bind mdrop_addr_filter mdrop_addr_filter_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_valid     (rx_valid),
    .rx_is_addr   (rx_is_addr),
    .rx_frame_err (rx_frame_err),
    .mode_sel     (mode_sel),
    .mp_enable    (mp_enable),
    .rx_irq       (rx_irq),
    .new_frame    (new_frame),
    .addr_flag    (addr_flag)
);

// File: tb/mdrop_addr_filter_test.sv
`timescale 1ns/1ps
module mdrop_addr_filter_test;

    localparam logic [7:0] OWN = 8'h5A;
    localparam int NV = 21;

    // Vector layout: [15]=enable [14:13]=mode [12]=addr marker [11]=framing err
    //                [10:3]=byte [2]=exp irq [1]=exp new_frame [0]=exp addr_flag
    localparam logic [15:0] VEC [NV] = '{
        {1'b0, 2'b00, 1'b1, 1'b0, 8'h33, 3'b101},  // 0  R2
        {1'b0, 2'b00, 1'b0, 1'b1, 8'h11, 3'b100},  // 1  R2
        {1'b1, 2'b01, 1'b1, 1'b0, 8'h77, 3'b101},  // 2  R4
        {1'b1, 2'b01, 1'b0, 1'b0, 8'h12, 3'b000},  // 3  R4
        {1'b1, 2'b00, 1'b0, 1'b0, 8'h13, 3'b100},  // 4  R5
        {1'b1, 2'b00, 1'b1, 1'b0, 8'h22, 3'b101},  // 5  R5
        {1'b1, 2'b10, 1'b0, 1'b0, 8'h44, 3'b000},  // 6  R12
        {1'b1, 2'b10, 1'b1, 1'b0, 8'h5A, 3'b101},  // 7  R7
        {1'b1, 2'b10, 1'b0, 1'b1, 8'h01, 3'b000},  // 8  R11
        {1'b1, 2'b10, 1'b0, 1'b0, 8'h02, 3'b110},  // 9  R9
        {1'b1, 2'b10, 1'b0, 1'b0, 8'h03, 3'b100},  // 10 R7
        {1'b1, 2'b10, 1'b1, 1'b0, 8'h5B, 3'b001},  // 11 R8
        {1'b1, 2'b10, 1'b0, 1'b0, 8'h04, 3'b000},  // 12 R8
        {1'b1, 2'b10, 1'b1, 1'b0, 8'h5A, 3'b101},  // 13 R7
        {1'b1, 2'b10, 1'b0, 1'b0, 8'h05, 3'b110},  // 14 R9
        {1'b1, 2'b11, 1'b1, 1'b0, 8'h5A, 3'b001},  // 15 R10
        {1'b1, 2'b11, 1'b0, 1'b0, 8'h06, 3'b110},  // 16 R10
        {1'b1, 2'b11, 1'b0, 1'b1, 8'h07, 3'b000},  // 17 R11
        {1'b1, 2'b11, 1'b0, 1'b0, 8'h08, 3'b100},  // 18 R10
        {1'b1, 2'b11, 1'b1, 1'b0, 8'hA5, 3'b001},  // 19 R8
        {1'b1, 2'b11, 1'b0, 1'b0, 8'h09, 3'b000}   // 20 R8
    };

    logic       clk = 1'b0;
    logic       rst_n;
    logic       rx_valid;
    logic [7:0] rx_data;
    logic       rx_is_addr;
    logic       rx_frame_err;
    logic [1:0] mode_sel;
    logic       mp_enable;
    logic [7:0] own_addr;
    logic       rx_irq;
    logic       new_frame;
    logic       addr_flag;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    mdrop_addr_filter uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_valid     (rx_valid),
        .rx_data      (rx_data),
        .rx_is_addr   (rx_is_addr),
        .rx_frame_err (rx_frame_err),
        .mode_sel     (mode_sel),
        .mp_enable    (mp_enable),
        .own_addr     (own_addr),
        .rx_irq       (rx_irq),
        .new_frame    (new_frame),
        .addr_flag    (addr_flag)
    );

    function automatic string tag_of(input int i);
        case (i)
            0, 1:            return "R2";
            2, 3:            return "R4";
            4, 5:            return "R5";
            6:               return "R12";
            7, 10, 13:       return "R7";
            8, 17:           return "R11";
            9, 14:           return "R9";
            11, 12, 19, 20:  return "R8";
            default:         return "R10";
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    task automatic set_cfg(input logic en, input logic [1:0] md);
        if (en !== mp_enable || md !== mode_sel) begin
            @(posedge clk);
            #1;
            mp_enable = en;
            mode_sel  = md;
        end
    endtask

    task automatic send(input string req, input logic ia, input logic fe,
                        input logic [7:0] d, input logic e_irq,
                        input logic e_nf, input logic e_af);
        @(posedge clk);
        #1;
        rx_valid     = 1'b1;
        rx_is_addr   = ia;
        rx_frame_err = fe;
        rx_data      = d;
        @(negedge clk);
        check(req, "irq", rx_irq, e_irq);
        @(posedge clk);
        #1;
        rx_valid = 1'b0;
        @(negedge clk);
        check("R3", "irq after strobe", rx_irq, 1'b0);
        check(req, "new_frame", new_frame, e_nf);
        check(req, "addr_flag", addr_flag, e_af);
    endtask

    initial begin
        #(5.0 * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst_n        = 1'b0;
        rx_valid     = 1'b0;
        rx_data      = 8'h00;
        rx_is_addr   = 1'b0;
        rx_frame_err = 1'b0;
        mode_sel     = 2'b00;
        mp_enable    = 1'b0;
        own_addr     = OWN;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "irq in reset", rx_irq, 1'b0);
        check("R1", "new_frame in reset", new_frame, 1'b0);
        check("R1", "addr_flag in reset", addr_flag, 1'b0);
        @(posedge clk);
        #1;
        rst_n = 1'b1;

        // R1: no frame accepted out of reset.
        set_cfg(1'b1, 2'b10);
        send("R1", 1'b0, 1'b0, 8'hC3, 1'b0, 1'b0, 1'b0);
        set_cfg(1'b0, 2'b00);

        for (int i = 0; i < NV; i++) begin
            set_cfg(VEC[i][15], VEC[i][14:13]);
            send(tag_of(i), VEC[i][12], VEC[i][11], VEC[i][10:3],
                 VEC[i][2], VEC[i][1], VEC[i][0]);
        end

        // R12: mode change drops an accepted frame.
        send("R10", 1'b1, 1'b0, OWN, 1'b0, 1'b0, 1'b1);
        set_cfg(1'b1, 2'b10);
        send("R12", 1'b0, 1'b0, 8'h66, 1'b0, 1'b0, 1'b0);

        // R6: flags hold across idle cycles.
        send("R7", 1'b1, 1'b0, OWN, 1'b1, 1'b0, 1'b1);
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R6", "addr_flag held", addr_flag, 1'b1);
        check("R6", "new_frame held low", new_frame, 1'b0);
        send("R9", 1'b0, 1'b0, 8'h10, 1'b1, 1'b1, 1'b0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R6", "new_frame held high", new_frame, 1'b1);
        check("R6", "addr_flag held low", addr_flag, 1'b0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule